// File: doc/BRIEF.md
# Compare-Match Timer with Waveform Outputs

This block is an 8-bit up-counter with two compare channels. Each channel drives one output pad. The counter advances once per prescaler clock-enable pulse. The pulse is generated outside the block and is, for example, high for one I/O clock in every eight. The counter runs in one of two ways:

- **Free-running mode:** it wraps from 255 to 0.
- **Clear-on-match mode:** it returns to zero after the tick in which it equals the channel A compare value.

On every tick, each channel compares the counter with its own compare value. On a match, the channel raises a sticky flag and applies a selectable action to its output register: toggle, clear or set.

A single control register selects the output action of each channel and the counting mode. A channel with a nonzero action field takes its pad over from the ordinary port data. The pad driver is enabled only by the pin's direction bit. Software clears a flag by pulsing a 1 on that channel's clear input. The asynchronous reset is released through an internal two-stage synchronizer, so the block leaves reset two clocks after `rst_n` rises.

Top module: `tc_ctc_timer`

## Requirements
- R1: While in reset, and after it, before any tick or write: the counter is 0, both flags are 0, the control register reads 0 and both channel output registers are 0.
- R2: The control register holds the following fields; bits 3:2 always read 0 and writes to them are discarded.
  - Bits 7:6: channel A action.
  - Bits 5:4: channel B action.
  - Bits 1:0: counting mode.
- R3: The counter changes only on a clock with `tick_en` high. In any counting mode other than 2'b10 it adds 1 per tick and wraps from 255 to 0.
- R4: In counting mode 2'b10, a tick taken while the counter equals `cmp_a` makes the counter 0. Any other tick adds 1, and a counter above `cmp_a` still runs on through 255 to 0.
- R5: A tick taken while the counter equals a channel's compare value sets that channel's flag after the edge. The flag then stays set until a clock with that channel's `flag_clr` bit at 1. A 0 in `flag_clr` has no effect, and a match in the same clock as a clear leaves the flag set.
- R6: On the same edge that sets the flag, the channel's output register is updated according to the channel's action code:
  - 01: inverted.
  - 10: cleared.
  - 11: set.
  - 00: left unchanged.
- R7: `pad_oe` of a channel equals its `dir_en` bit. `pad_val` shows the channel output register when the channel's action code is nonzero, and shows `port_dout` otherwise.
- R8: With ticks every 8 clocks, the counter holds its value for the 7 clocks between ticks and steps once per tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaler clock enable, one tick per high clock |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| cmp_a | input | 8 | Channel A compare value (also the top in clear-on-match mode) |
| cmp_b | input | 8 | Channel B compare value |
| flag_clr | input | 2 | Write-1-to-clear for flags; bit 0 is A, bit 1 is B |
| dir_en | input | 2 | Pin direction bits; 1 enables the pad driver |
| port_dout | input | 2 | Ordinary port data used when a channel is disconnected |
| count | output | 8 | Current counter value |
| match_flag | output | 2 | Sticky compare flags; bit 0 is A, bit 1 is B |
| pad_val | output | 2 | Pad output value per channel |
| pad_oe | output | 2 | Pad driver enable per channel |

## Verification
The bench goes after the following corner cases:

- **Top values of 0 and 1:** the counter sits at or alternates near zero. A design that compares against the next value instead of the present one would skip the match entirely.
- **Top moved below the running count:** the counter must run through 255 and wrap. A design that clears on "greater or equal" would jump straight to 0.
- **Clear in the same clock as a match:** a clear pulse is held during every tick, including the match ticks. A design that gave the clear priority would never show the flag.
- **Prescaled ticks and reserved bits:** with divide-by-8 ticks, a counter that moves on a plain clock shows up at once. Writing all ones to the control register exposes any storage kept in the reserved bits.

// File: rtl/tc_pkg.sv
package tc_pkg;

  // Output action taken by a channel on a compare match.
  typedef enum logic [1:0] {
    OC_OFF    = 2'b00,
    OC_TOGGLE = 2'b01,
    OC_CLEAR  = 2'b10,
    OC_SET    = 2'b11
  } oc_act_e;

  // Counting mode code that selects clear-on-match; every other code counts freely.
  localparam logic [1:0] WAVE_CTC = 2'b10;

  typedef struct packed {
    oc_act_e    act_a;
    oc_act_e    act_b;
    logic [1:0] wave;
  } tc_ctl_t;

endpackage

// File: rtl/tc_rst_sync.sv
module tc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tc_ctl_reg.sv
module tc_ctl_reg
  import tc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output tc_ctl_t    ctl_q,
  output logic [7:0] ctl_rdata
);
  tc_ctl_t ctl_d;
  logic    unused_rsvd;

  assign unused_rsvd = ^ctl_wdata[3:2];

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we) begin
      ctl_d.act_a = oc_act_e'(ctl_wdata[7:6]);
      ctl_d.act_b = oc_act_e'(ctl_wdata[5:4]);
      ctl_d.wave  = ctl_wdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '{act_a: OC_OFF, act_b: OC_OFF, wave: 2'b00};
    else        ctl_q <= ctl_d;
  end

  assign ctl_rdata = {ctl_q.act_a, ctl_q.act_b, 2'b00, ctl_q.wave};

  // R2: without a write strobe the register keeps its value
  a_r2_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(ctl_rdata));

  // R2: a write lands in the fields it addresses
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (ctl_rdata[7:4] == $past(ctl_wdata[7:4])) && (ctl_rdata[1:0] == $past(ctl_wdata[1:0])));
endmodule

// File: rtl/tc_counter.sv
module tc_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             ctc_mode,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;
  logic             at_top;

  assign at_top = ctc_mode && (cnt_q == top);

  always_comb begin
    cnt_d = cnt_q;
    if (tick_en) begin
      if (at_top) cnt_d = '0;
      else        cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3 / R8: no tick, no movement
  a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q));

  // R4: clear-on-match returns to zero after the top count
  a_r4_wrap_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && ctc_mode && cnt_q == top) |=> (cnt_q == '0));

  // R3: free-running counting steps by one
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !ctc_mode) |=> (cnt_q == CNT_W'($past(cnt_q) + ONE)));
endmodule

// File: rtl/tc_cmp_chan.sv
module tc_cmp_chan
  import tc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  oc_act_e          act,
  input  logic             clr,
  input  logic             dir,
  input  logic             port_dout,
  output logic             flag_q,
  output logic             pad_val,
  output logic             pad_oe
);
  logic match;
  logic flag_d;
  logic oc_q, oc_d;

  assign match = tick_en && (cnt == cmp);

  always_comb begin
    flag_d = flag_q;
    if (match)    flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_comb begin
    oc_d = oc_q;
    if (match) begin
      unique case (act)
        OC_TOGGLE: oc_d = ~oc_q;
        OC_CLEAR:  oc_d = 1'b0;
        OC_SET:    oc_d = 1'b1;
        default:   oc_d = oc_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      oc_q   <= 1'b0;
    end else begin
      flag_q <= flag_d;
      oc_q   <= oc_d;
    end
  end

  assign pad_val = (act != OC_OFF) ? oc_q : port_dout;
  assign pad_oe  = dir;

  // R5: a match raises the flag
  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag_q);

  // R5: the flag is sticky without a clear
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  // R6: output register moves only on ticks
  a_r6_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(oc_q));

  // R6: the set and clear actions
  a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
    (match && act == OC_SET) |=> oc_q);

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (match && act == OC_CLEAR) |=> !oc_q);

  // R6: the toggle action
  a_r6_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (match && act == OC_TOGGLE) |=> (oc_q != $past(oc_q)));
endmodule

// File: rtl/tc_ctc_timer.sv
module tc_ctc_timer
  import tc_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  output logic [7:0]       ctl_rdata,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [1:0]       flag_clr,
  input  logic [1:0]       dir_en,
  input  logic [1:0]       port_dout,
  output logic [CNT_W-1:0] count,
  output logic [1:0]       match_flag,
  output logic [1:0]       pad_val,
  output logic [1:0]       pad_oe
);
  localparam int NUM_CH = 2;

  logic             rst_int_n;
  tc_ctl_t          ctl_q;
  logic             ctc_mode;
  logic [CNT_W-1:0] cmp_arr [NUM_CH];
  oc_act_e          act_arr [NUM_CH];

  tc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  tc_ctl_reg u_ctl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .ctl_q     (ctl_q),
    .ctl_rdata (ctl_rdata)
  );

  assign ctc_mode   = (ctl_q.wave == WAVE_CTC);
  assign cmp_arr[0] = cmp_a;
  assign cmp_arr[1] = cmp_b;
  assign act_arr[0] = ctl_q.act_a;
  assign act_arr[1] = ctl_q.act_b;

  tc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick_en  (tick_en),
    .ctc_mode (ctc_mode),
    .top      (cmp_a),
    .cnt_q    (count)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tc_cmp_chan #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .tick_en   (tick_en),
      .cnt       (count),
      .cmp       (cmp_arr[c]),
      .act       (act_arr[c]),
      .clr       (flag_clr[c]),
      .dir       (dir_en[c]),
      .port_dout (port_dout[c]),
      .flag_q    (match_flag[c]),
      .pad_val   (pad_val[c]),
      .pad_oe    (pad_oe[c])
    );
  end

  // R1: in reset the visible state is all zero
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_int_n |-> (count == '0 && match_flag == 2'b00 && ctl_rdata == 8'h00));
endmodule

// File: tb/tb_tc_ctc_timer.sv
`timescale 1ns/1ps
module tb_tc_ctc_timer;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_en;
  logic       ctl_we;
  logic [7:0] ctl_wdata;
  logic [7:0] ctl_rdata;
  logic [7:0] cmp_a, cmp_b;
  logic [1:0] flag_clr, dir_en, port_dout;
  logic [7:0] count;
  logic [1:0] match_flag, pad_val, pad_oe;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0] m_cnt;
  logic [7:0] m_ctl;
  logic [1:0] m_flag, m_oc;

  always #5 clk = ~clk;

  tc_ctc_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .cmp_a(cmp_a), .cmp_b(cmp_b),
    .flag_clr(flag_clr), .dir_en(dir_en), .port_dout(port_dout), .count(count),
    .match_flag(match_flag), .pad_val(pad_val), .pad_oe(pad_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_pad();
    logic [1:0] r;
    r[0] = (m_ctl[7:6] != 2'b00) ? m_oc[0] : port_dout[0];
    r[1] = (m_ctl[5:4] != 2'b00) ? m_oc[1] : port_dout[1];
    return r;
  endfunction

  task automatic check_all(input string ctag);
    chk({ctag, " count"}, 32'(count), 32'(m_cnt));
    chk("R5 flags", 32'(match_flag), 32'(m_flag));
    chk("R6 pad_val", 32'(pad_val), 32'(exp_pad()));
    chk("R7 pad_oe", 32'(pad_oe), 32'(dir_en));
  endtask

  // One clock; the model follows the requirements for the edge.
  task automatic step(input logic tk, input logic [1:0] clr, input string ctag);
    logic [1:0] acts [2];
    logic [7:0] cmps [2];
    tick_en  = tk;
    flag_clr = clr;
    @(posedge clk);
    acts[0] = m_ctl[7:6]; acts[1] = m_ctl[5:4];
    cmps[0] = cmp_a;      cmps[1] = cmp_b;
    for (int c = 0; c < 2; c++) begin
      if (tk && m_cnt == cmps[c]) begin
        m_flag[c] = 1'b1;
        case (acts[c])
          2'b01: m_oc[c] = ~m_oc[c];
          2'b10: m_oc[c] = 1'b0;
          2'b11: m_oc[c] = 1'b1;
          default: ;
        endcase
      end else if (clr[c]) begin
        m_flag[c] = 1'b0;
      end
    end
    if (tk) m_cnt = (m_ctl[1:0] == 2'b10 && m_cnt == cmp_a) ? 8'd0 : m_cnt + 8'd1;
    @(negedge clk);
    tick_en  = 1'b0;
    flag_clr = 2'b00;
    check_all(ctag);
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    ctl_we = 1'b1; ctl_wdata = d;
    @(posedge clk);
    m_ctl = d & 8'hF3;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_err++; n_chk++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; ctl_we = 1'b0; ctl_wdata = 8'h00;
    cmp_a = 8'd0; cmp_b = 8'd0; flag_clr = 2'b00; dir_en = 2'b00; port_dout = 2'b00;
    m_cnt = 8'd0; m_ctl = 8'd0; m_flag = 2'b00; m_oc = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state held in reset
    chk("R1 count", 32'(count), 0);
    chk("R1 flags", 32'(match_flag), 0);
    chk("R1 ctl", 32'(ctl_rdata), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 count after release", 32'(count), 0);

    // R1: output registers start at 0, seen through connected pads
    dir_en = 2'b11; port_dout = 2'b11;
    wr_ctl(8'hF0);
    chk("R1 oc regs", 32'(pad_val), 0);
    chk("R7 pad_oe", 32'(pad_oe), 3);

    // R2: reserved bits read 0, field writes land
    wr_ctl(8'hFF);
    chk("R2 rdata all ones", 32'(ctl_rdata), 32'h F3);
    wr_ctl(8'h0C);
    chk("R2 reserved only", 32'(ctl_rdata), 0);
    wr_ctl(8'h5A);
    chk("R2 mixed", 32'(ctl_rdata), 32'h52);

    // R3: free-running with toggle on A, set on B, wrap through 255
    wr_ctl(8'h70); cmp_a = 8'd5; cmp_b = 8'd250;
    for (int i = 0; i < 300; i++) step(1'b1, 2'b00, "R3");
    // R3: undefined mode code 2'b11 still counts freely
    wr_ctl(8'h73);
    for (int i = 0; i < 260; i++) step(1'b1, 2'b00, "R3");
    // R5: write of 0 keeps flags, write of 1 clears them
    step(1'b0, 2'b00, "R5");
    chk("R5 flags kept", 32'(match_flag), 3);
    step(1'b0, 2'b11, "R5");
    chk("R5 flags cleared", 32'(match_flag), 0);

    // R4 / R6: clear-on-match sweep over several tops and actions
    begin
      logic [7:0] tops [5];
      logic [1:0] acts [3];
      tops[0] = 8'd0; tops[1] = 8'd1; tops[2] = 8'd3; tops[3] = 8'd7; tops[4] = 8'd20;
      acts[0] = 2'b01; acts[1] = 2'b11; acts[2] = 2'b10;
      for (int t = 0; t < 5; t++) begin
        for (int a = 0; a < 3; a++) begin
          wr_ctl({acts[a], 2'b01, 2'b00, 2'b10});
          cmp_a = tops[t]; cmp_b = tops[t] >> 1;
          for (int i = 0; i < 270 + 3 * int'(tops[t]); i++)
            step(1'b1, (t == 2) ? 2'b01 : 2'b00, "R4");
        end
      end
    end

    // R8: divide-by-8 ticks, clear-on-match at 9, mixed pad routing (R7)
    wr_ctl(8'hC2); cmp_a = 8'd9; cmp_b = 8'd4;
    dir_en = 2'b01; port_dout = 2'b10;
    for (int p = 0; p < 40; p++)
      for (int k = 0; k < 8; k++) step(k == 7, 2'b00, "R8");
    dir_en = 2'b00; port_dout = 2'b01;
    for (int p = 0; p < 5; p++)
      for (int k = 0; k < 8; k++) step(k == 7, 2'b00, "R8");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule